// File: doc/BRIEF.md
# Preemptive Priority Interrupt Arbiter

This block chooses which of a set of request lines interrupts a single processor. Each source has a programmable priority level. The block keeps a running current-priority value that belongs to the handler now executing. A request can interrupt only when its level is strictly above that value. Among the requests that qualify, the highest level wins. When several share that top level, the lowest source index wins, whatever order they rose in.

When the processor acknowledges the interrupt, the arbiter does two things: it saves the current priority on an internal last-in-first-out store, and it raises the current priority to the level of the source being serviced. An end-of-interrupt strobe pops the store, which returns the priority to the level of the interrupted handler. Requests that had to wait behind the finished handler are then considered again.

The control path is a two-state machine:
- IDLE: no interrupt is offered.
  - Transition SELECT moves to PRESENT when a pending request beats the current priority. The winner's index and level are registered at this point.
- PRESENT: `irq_o` is high and the registered index is offered on `vec_o`.
  - Transition ACCEPT returns to IDLE on an acknowledge.
  - Transition WITHDRAW returns to IDLE when the offered source drops its request before it is acknowledged.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, `irq_o` is 0, `cur_prio_o` is 0 and `err_o` is 0.
- R2: A request raises `irq_o` only when its priority is strictly greater than `cur_prio_o`. A request at or below the current level, and any request at level 0, stays pending with `irq_o` low.
- R3: Among pending requests, the one with the highest priority is offered, even when its source index is larger.
- R4: When several pending requests share the top priority, the lowest source index is offered, whatever order they asserted in.
- R5: `irq_o` rises one clock after a qualifying request is first seen in IDLE, and `vec_o` carries the 4-bit index of the offered source (source n gives value n).
- R6: While `irq_o` is high, `vec_o` stays constant until acknowledge, as long as the offered source keeps requesting, even if a better request arrives meanwhile. If the offered source deasserts before acknowledge, `irq_o` drops on the next clock.
- R7: An `ack_i` pulse while `irq_o` is high has two effects on the next clock: `cur_prio_o` takes the offered source's level, and `irq_o` goes low. An `ack_i` pulse while `irq_o` is low changes nothing.
- R8: An `eoi_i` pulse restores `cur_prio_o` to the value it had before the most recent accepted interrupt. Pending requests above the restored level are then offered.
- R9: An `eoi_i` pulse with nothing saved sets `cur_prio_o` to 0 and sets `err_o`. `err_o` then stays 1 until reset.
- R10: When `ack_i` is accepted in the same cycle as an `eoi_i` pulse, the `eoi_i` pulse is ignored.
- R11: The saved-priority store never overflows. Its depth equals the number of priority levels, and each accepted interrupt strictly raises the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Level-sensitive request lines, one per source |
| prio_cfg_i | input | NUM_SRC*PRIO_W | Per-source priority level; source n uses bits [n*PRIO_W +: PRIO_W] |
| ack_i | input | 1 | Acknowledge strobe; accepts the vector offered in the same cycle |
| eoi_i | input | 1 | End-of-interrupt strobe; restores the previous priority |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Index of the offered source |
| cur_prio_o | output | PRIO_W | Current priority level |
| err_o | output | 1 | Sticky flag: end-of-interrupt received with nothing saved |

## Verification
A corrupted saved-priority entry or stack pointer shows up at the ports on the clock after the next `eoi_i`. Either `cur_prio_o` returns to the wrong level, or a waiting request is offered too early or never. A wrong selection shows as a wrong `vec_o` one clock after the request rises. A latch that fails to hold shows as `vec_o` moving before the acknowledge. A mishandled acknowledge shows as `cur_prio_o` not matching the serviced level on the following clock, or as the same source being offered twice.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irq_arb_select.sv
module irq_arb_select #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 4
) (
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_cfg_i,
    output logic                      found_o,
    output logic [VEC_W-1:0]          idx_o,
    output logic [PRIO_W-1:0]         prio_o
);
    // Ascending scan with strict compare: the lowest index keeps a tie.
    // Level 0 can never win because nothing is strictly above 0.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (prio_cfg_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
                found_o = 1'b1;
                idx_o   = VEC_W'(i);
                prio_o  = prio_cfg_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_arb_prio_stack.sv
module irq_arb_prio_stack #(
    parameter int PRIO_W = 4,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] new_prio_i,
    output logic [PRIO_W-1:0] cur_o,
    output logic              err_o
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPW = $clog2(DEPTH + 1);

    logic [PRIO_W-1:0] saved_q [DEPTH];
    logic [SPW-1:0]    sp_q;
    logic [SPW-1:0]    sp_dec;

    assign sp_dec = sp_q - SPW'(1);

    always_ff @(posedge clk) begin
        if (push_i) begin
            saved_q[sp_q[AW-1:0]] <= cur_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            cur_o <= '0;
            err_o <= 1'b0;
        end else if (push_i) begin
            sp_q  <= sp_q + SPW'(1);
            cur_o <= new_prio_i;
        end else if (pop_i) begin
            if (sp_q == '0) begin
                cur_o <= '0;
                err_o <= 1'b1;
            end else begin
                sp_q  <= sp_dec;
                cur_o <= saved_q[sp_dec[AW-1:0]];
            end
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (sp_q < SPW'(DEPTH)));
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && sp_q == '0) |=> (err_o && cur_o == '0));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    assert_push_pop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_SRC-1:0]                    req_i,
    input  logic [NUM_SRC*PRIO_W-1:0]             prio_cfg_i,
    input  logic                                  ack_i,
    input  logic                                  eoi_i,
    output logic                                  irq_o,
    output logic [$clog2(NUM_SRC)-1:0]            vec_o,
    output logic [PRIO_W-1:0]                     cur_prio_o,
    output logic                                  err_o
);
    import irq_arb_pkg::*;

    localparam int VEC_W   = $clog2(NUM_SRC);
    localparam int NUM_LVL = 1 << PRIO_W;

    arb_state_e        state_q, state_d;
    logic              found;
    logic [VEC_W-1:0]  best_idx;
    logic [PRIO_W-1:0] best_prio;
    logic [PRIO_W-1:0] prio_q;
    logic              take, accept, pop;

    irq_arb_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_select (
        .req_i      (req_i),
        .prio_cfg_i (prio_cfg_i),
        .found_o    (found),
        .idx_o      (best_idx),
        .prio_o     (best_prio)
    );

    assign take   = found && (best_prio > cur_prio_o);
    assign accept = (state_q == ST_PRESENT) && ack_i;
    assign pop    = eoi_i && !accept;
    assign irq_o  = (state_q == ST_PRESENT);

    irq_arb_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(NUM_LVL)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (accept),
        .pop_i      (pop),
        .new_prio_i (prio_q),
        .cur_o      (cur_prio_o),
        .err_o      (err_o)
    );

    // Next state: SELECT, ACCEPT, WITHDRAW
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (ack_i)              state_d = ST_IDLE;
                else if (!req_i[vec_o]) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Offered vector and level: captured on SELECT, held while PRESENT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o  <= '0;
            prio_q <= '0;
        end else if (state_q == ST_IDLE && take) begin
            vec_o  <= best_idx;
            prio_q <= best_prio;
        end
    end

    assert_beats_cur_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (prio_q > cur_prio_o));
    assert_hold_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && req_i[vec_o]) |=> (irq_o && $stable(vec_o)));
    assert_withdraw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && !req_i[vec_o]) |=> !irq_o);
    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> (!irq_o && cur_prio_o == $past(prio_q)));
endmodule

// File: tb/prio_irq_arbiter_test.sv
`timescale 1ns/100ps
module prio_irq_arbiter_test;
    localparam int N  = 16;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*PW-1:0] prio_cfg = '0;
    logic          ack = 1'b0;
    logic          eoi = 1'b0;
    logic          irq;
    logic [3:0]    vec;
    logic [PW-1:0] cur;
    logic          err;

    always #2.5 clk = ~clk;

    prio_irq_arbiter #(.NUM_SRC(N), .PRIO_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_cfg_i(prio_cfg),
        .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .vec_o(vec),
        .cur_prio_o(cur), .err_o(err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int    exp_vec_q[$];
    string exp_tag_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compare each accepted vector with the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && irq && ack) begin
            if (exp_vec_q.size() == 0) begin
                check(1'b0, "R5 accept with empty scoreboard", int'(vec), -1);
            end else begin
                int    e;
                string t;
                e = exp_vec_q.pop_front();
                t = exp_tag_q.pop_front();
                check(int'(vec) == e, t, int'(vec), e);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_prio(input int src, input int lvl);
        prio_cfg[src*PW +: PW] = PW'(lvl);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; ack = 1'b0; eoi = 1'b0;
        repeat (3) step();
        check(!irq && cur == 0 && !err, "R1 reset state", int'({irq, cur, err}), 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic wait_irq(input string tag);
        int k = 0;
        while (!irq && k < 50) begin
            step();
            k++;
        end
        if (!irq) check(1'b0, tag, 0, 1);
    endtask

    // Driver: push the expected vector, wait for the offer, acknowledge
    task automatic take(input int v, input int p, input string tag, input bit with_eoi = 1'b0);
        exp_vec_q.push_back(v);
        exp_tag_q.push_back(tag);
        wait_irq(tag);
        ack = 1'b1;
        eoi = with_eoi;
        step();
        ack = 1'b0;
        eoi = 1'b0;
        check(int'(cur) == p, "R7 level after accept", int'(cur), p);
        check(!irq, "R7 irq low after accept", int'(irq), 0);
    endtask

    task automatic do_eoi(input int p, input string tag);
        eoi = 1'b1;
        step();
        eoi = 1'b0;
        check(int'(cur) == p, tag, int'(cur), p);
    endtask

    initial begin
        set_prio(7, 0); set_prio(1, 1); set_prio(4, 4); set_prio(3, 3);
        set_prio(2, 3); set_prio(0, 2); set_prio(9, 7); set_prio(5, 5);
        set_prio(6, 9);
        do_reset();

        // R2: level 0 never interrupts
        req[7] = 1'b1;
        repeat (3) begin
            step();
            check(!irq, "R2 level-0 request stays pending", int'(irq), 0);
        end
        req[7] = 1'b0;

        // R5: one-cycle latency and index on vec
        req[1] = 1'b1;
        step();
        check(irq && vec == 4'd1, "R5 offer one clock after request", int'(vec), 1);
        take(1, 1, "R5 vector of source 1");
        req[1] = 1'b0;

        // R3: higher level preempts running handler
        req[4] = 1'b1;
        take(4, 4, "R3 level 4 preempts level 1");
        req[4] = 1'b0;

        // R2: equal and lower levels wait; R4 arrival order irrelevant
        req[3] = 1'b1;
        step();
        req[2] = 1'b1;
        repeat (3) begin
            step();
            check(!irq, "R2 level 3 under level 4 stays pending", int'(irq), 0);
        end
        do_eoi(1, "R8 restore level 1 after level 4");
        take(2, 3, "R4 lowest index wins tie though later");
        req[2] = 1'b0;
        do_eoi(1, "R8 restore level 1 after first level 3");
        take(3, 3, "R8 remaining level-3 source offered");
        req[3] = 1'b0;
        do_eoi(1, "R8 restore level 1");
        do_eoi(0, "R8 restore base level 0");
        check(!err, "R9 no error while store non-empty", int'(err), 0);
        do_eoi(0, "R9 empty pop leaves level 0");
        check(err, "R9 error set on empty pop", int'(err), 1);
        step();
        check(err, "R9 error is sticky", int'(err), 1);

        // R3: higher level beats lower index
        do_reset();
        req[0] = 1'b1;
        req[9] = 1'b1;
        take(9, 7, "R3 source 9 level 7 over source 0 level 2");
        req[9] = 1'b0;
        do_eoi(0, "R8 back to level 0");
        take(0, 2, "R8 waiting source 0 offered after eoi");
        req[0] = 1'b0;
        do_eoi(0, "R8 back to level 0 again");

        // R6: hold and withdraw
        req[5] = 1'b1;
        wait_irq("R6 offer source 5");
        check(vec == 4'd5, "R6 offered vector", int'(vec), 5);
        req[6] = 1'b1;
        repeat (2) begin
            step();
            check(irq && vec == 4'd5, "R6 vector held despite better request", int'(vec), 5);
        end
        req[5] = 1'b0;
        step();
        check(!irq, "R6 withdraw drops irq", int'(irq), 0);

        // R10: ack with eoi, eoi ignored
        take(6, 9, "R10 accept with simultaneous eoi", 1'b1);
        check(!err, "R10 eoi ignored, no error", int'(err), 0);

        // R7: ack while idle ignored
        req[6] = 1'b0;
        step();
        ack = 1'b1;
        step();
        ack = 1'b0;
        check(cur == 4'd9 && !irq, "R7 idle ack ignored", int'(cur), 9);
        do_eoi(0, "R8 restore 0 after level 9");
        check(!err, "R9 error clear after valid pops", int'(err), 0);
        check(exp_vec_q.size() == 0, "R5 all expected accepts seen", exp_vec_q.size(), 0);

        step();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule